// File: doc/BRIEF.md
# Clock-Stepped Program Memory Programming Port

This block is the device-side control for programming and reading back a one-time program memory of 16,384 words. The memory has no address pins. An internal word address starts at zero on a dedicated mode code. A programming clock pin then steps it. Every group of four rising edges on that pin forms one cycle, and the address moves up by one on the third edge of each group.

Four mode pins choose what happens at the current address. One code clears the address. Another code accepts a byte from the data bus and commits it to the array. A third code drives the stored byte back onto the bus. The remaining codes leave the array untouched and the bus released.

The bidirectional data bus appears as a separate input, output and output-enable, so the pad ring can build the tri-state driver. The array is reached through a simple synchronous port: write strobe, read enable, address and data. The pins are assumed to be synchronous to `clk`.

Top module: `pgm_serial_port`

## Requirements
- R1: After reset, `mem_addr` is 0, `dq_oe` is 0, `mem_we` is 0 and `addr_wrapped` is 0.
- R2: The mode code `md` = 4'b0101 (bit 0 = MD0) clears the address and the four-edge phase count to 0 on the next clock, and also clears `addr_wrapped`. An edge that arrives after the clear is counted from phase 0.
- R3: Only a rising edge of `pgm_clk` counts, and it counts only outside the clear code. The address rises by one on the 3rd counted edge of each group of four, and the 1st, 2nd and 4th edges leave it unchanged. The new address is visible one clock after the edge is sampled.
- R4: `md` = 4'b1110 is write mode. In this mode `dq_oe` stays 0 and the byte on `dq_in` is captured on every clock. When `md` leaves this code, `mem_we` pulses for exactly one clock, one clock later. The pulse carries the last captured byte on `mem_wdata` at the current `mem_addr`.
- R5: `md` = 4'b1100 is verify mode. `mem_re` is high while the code is present. One clock after entry, `dq_oe` is 1 and `dq_out` shows the array word at the current address.
- R6: Any code with MD0 high apart from the clear code, and every code not named in R2, R4 or R5, is inhibit. In inhibit, `dq_oe` is 0 and no `mem_we` pulse occurs.
- R7: When the address steps from 3FFFh, it becomes 0000h and `addr_wrapped` goes to 1. The flag stays at 1 until the clear code or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pgm_clk | input | 1 | Programming clock pin that steps the address |
| md | input | 4 | Mode pins, bit 0 = MD0 |
| dq_in | input | 8 | Data bus input value |
| dq_out | output | 8 | Data bus output value |
| dq_oe | output | 1 | Data bus output enable |
| mem_addr | output | 14 | Array word address |
| mem_wdata | output | 8 | Array write data |
| mem_we | output | 1 | Array write strobe, one clock wide |
| mem_re | output | 1 | Array read enable |
| mem_rdata | input | 8 | Array read data, one clock after the read |
| addr_wrapped | output | 1 | Sticky flag for an address wrap |

## Verification
A `pgm_clk` rise that is driven before a clock edge changes the address at that edge. The bench therefore reads the address at the following falling edge. A mode change likewise takes effect at the next rising edge: `dq_oe` and the array read data are checked half a clock after it, and so is the write strobe when write mode ends. Inputs are always changed on falling edges and outputs read there, so each check falls exactly one register stage after its stimulus. A monitor compares every write strobe with the address and byte that the driver queued when it ended write mode.

// File: rtl/pgm_serial_port.sv
module pgm_serial_port #(
  parameter int AW = 14,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pgm_clk,
  input  logic [3:0]    md,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          addr_wrapped
);
  localparam logic [3:0]    MD_CLEAR  = 4'b0101;
  localparam logic [3:0]    MD_WRITE  = 4'b1110;
  localparam logic [3:0]    MD_VERIFY = 4'b1100;
  localparam logic [1:0]    STEP_PH   = 2'd2;
  localparam logic [AW-1:0] ADDR_LAST = '1;

  logic          pclk_q, wr_q;
  logic [1:0]    phase;
  logic [DW-1:0] din_q;

  wire is_clear  = (md == MD_CLEAR);
  wire is_write  = (md == MD_WRITE);
  wire is_verify = (md == MD_VERIFY);
  wire pclk_rise = pgm_clk & ~pclk_q;

  assign mem_re = is_verify;
  assign dq_out = mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_q       <= 1'b0;
      phase        <= '0;
      mem_addr     <= '0;
      addr_wrapped <= 1'b0;
    end else begin
      pclk_q <= pgm_clk;
      if (is_clear) begin
        phase        <= '0;
        mem_addr     <= '0;
        addr_wrapped <= 1'b0;
      end else if (pclk_rise) begin
        phase <= phase + 2'd1;
        if (phase == STEP_PH) begin
          mem_addr <= mem_addr + 1'b1;
          if (mem_addr == ADDR_LAST) addr_wrapped <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b0;
      din_q     <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      dq_oe     <= 1'b0;
    end else begin
      wr_q <= is_write;
      if (is_write) din_q <= dq_in;
      mem_we    <= wr_q & ~is_write;
      mem_wdata <= din_q;
      dq_oe     <= is_verify;
    end
  end

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    is_clear |=> (mem_addr == '0) && !addr_wrapped); // R2
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr != $past(mem_addr)) |-> (mem_addr == '0) || (mem_addr == $past(mem_addr) + 1'b1)); // R3
  AST_STEP_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_addr != $past(mem_addr)) && (mem_addr != '0)) |-> ($past(pgm_clk) && !$past(pgm_clk, 2))); // R3
  AST_WE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R4
  AST_BUS_FREE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> !dq_oe); // R4
  AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_wrapped) |-> (mem_addr == '0)); // R7
endmodule

// File: tb/sim_pgm_serial_port.sv
module sim_pgm_serial_port;
  logic clk = 1'b0, rst_n = 1'b0, pgm_clk = 1'b0;
  logic [3:0] md = 4'b1101;
  logic [7:0] dq_in = '0, dq_out, mem_wdata, mem_rdata;
  logic [13:0] mem_addr;
  logic dq_oe, mem_we, mem_re, addr_wrapped;
  logic [7:0] bmem [256];
  int n_chk = 0, n_err = 0, n_we = 0;
  logic [21:0] exp_q [$];
  bit done = 1'b0;

  localparam logic [3:0] M_CLR = 4'b0101, M_WR = 4'b1110, M_VF = 4'b1100, M_INH = 4'b1101;

  always #4 clk = ~clk;

  pgm_serial_port u0 (.clk(clk), .rst_n(rst_n), .pgm_clk(pgm_clk), .md(md),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .addr_wrapped(addr_wrapped));

  initial for (int i = 0; i < 256; i++) bmem[i] = 8'(i) ^ 8'h3C;
  always @(posedge clk) begin
    if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= bmem[mem_addr[7:0]];
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for array writes (R4)
  always @(negedge clk) if (rst_n && mem_we) begin
    n_we++;
    if (exp_q.size() == 0) check("R4/R6 unexpected write", {10'd0, mem_addr, mem_wdata}, 32'hFFFFFFFF);
    else check("R4 write addr/data", {10'd0, mem_addr, mem_wdata}, {10'd0, exp_q.pop_front()});
  end

  task automatic set_md(logic [3:0] m);
    @(negedge clk) md = m;
    @(negedge clk);
  endtask
  task automatic pulse();
    @(negedge clk) pgm_clk = 1'b1;
    @(negedge clk) pgm_clk = 1'b0;
  endtask
  task automatic write_byte(logic [13:0] a, logic [7:0] d);
    @(negedge clk) begin dq_in = d; md = M_WR; end
    @(negedge clk) check("R4 bus released in write", 32'(dq_oe), 0);
    @(negedge clk) dq_in = ~d;
    exp_q.push_back({a, d});
    @(negedge clk) begin dq_in = d; end
    @(negedge clk) md = M_INH;
    @(negedge clk) check("R4 strobe after exit", 32'(mem_we), 1);
    @(negedge clk) check("R4 strobe one clock", 32'(mem_we), 0);
  endtask

  task automatic finish_run();
    if (exp_q.size() != 0) check("R4 pending writes", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(190000 * 8);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int we0;
    repeat (3) @(negedge clk);
    check("R1 addr", 32'(mem_addr), 0);
    check("R1 oe", 32'(dq_oe), 0);
    check("R1 we", 32'(mem_we), 0);
    check("R1 wrapped", 32'(addr_wrapped), 0);
    @(negedge clk) rst_n = 1'b1;
    set_md(M_CLR);
    check("R2 clear addr", 32'(mem_addr), 0);
    set_md(M_INH);
    check("R6 inhibit oe", 32'(dq_oe), 0);
    // R4 write at address 0
    write_byte(14'd0, 8'hA5);
    set_md(M_VF);
    check("R5 oe in verify", 32'(dq_oe), 1);
    check("R5 read back addr0", 32'(dq_out), 32'hA5);
    set_md(M_INH);
    check("R6 oe after verify", 32'(dq_oe), 0);
    // R3 stepping
    pulse(); check("R3 edge1 no step", 32'(mem_addr), 0);
    pulse(); check("R3 edge2 no step", 32'(mem_addr), 0);
    pulse(); check("R3 edge3 step", 32'(mem_addr), 1);
    pulse(); check("R3 edge4 no step", 32'(mem_addr), 1);
    // held-high pgm_clk counts once
    @(negedge clk) pgm_clk = 1'b1;
    repeat (4) @(negedge clk);
    pgm_clk = 1'b0;
    pulse(); pulse();
    check("R3 level not counted", 32'(mem_addr), 2);
    pulse();
    check("R3 next group edge4", 32'(mem_addr), 2);
    write_byte(14'd2, 8'h5A);
    set_md(M_VF);
    check("R5 read back addr2", 32'(dq_out), 32'h5A);
    pulse(); pulse(); pulse();
    @(negedge clk);
    check("R5 verify after step", 32'(dq_out), 32'(8'd3 ^ 8'h3C));
    set_md(M_INH);
    // R6 unlisted code
    we0 = n_we;
    @(negedge clk) begin md = 4'b0000; dq_in = 8'hFF; end
    repeat (3) @(negedge clk);
    check("R6 unlisted oe", 32'(dq_oe), 0);
    set_md(4'b1111);
    set_md(M_INH);
    repeat (2) @(negedge clk);
    check("R6 no write", n_we - we0, 0);
    // R2 phase clear
    set_md(M_CLR);
    set_md(M_INH);
    pulse();
    set_md(M_CLR);
    set_md(M_INH);
    pulse(); pulse();
    check("R2 phase cleared", 32'(mem_addr), 0);
    pulse();
    check("R2 step after clear", 32'(mem_addr), 1);
    pulse();
    // R7 wrap
    set_md(M_CLR);
    set_md(M_INH);
    for (int k = 0; k < 16383 * 4; k++) pulse();
    check("R7 last address", 32'(mem_addr), 32'h3FFF);
    check("R7 flag before wrap", 32'(addr_wrapped), 0);
    repeat (4) pulse();
    check("R7 wrap to zero", 32'(mem_addr), 0);
    check("R7 flag set", 32'(addr_wrapped), 1);
    pulse(); pulse(); pulse();
    check("R7 flag sticky", 32'(addr_wrapped), 1);
    set_md(M_CLR);
    check("R2 clear drops flag", 32'(addr_wrapped), 0);
    done = 1'b1;
    finish_run();
  end
endmodule